// File: doc/BRIEF.md
# Deep Sleep Entry and Wake Sequencer

This block is the power-mode sequencer of a small microcontroller core. When the core issues a sleep instruction, it decides whether the device goes into deep sleep, with the core regulator switched off, or into ordinary sleep or idle. Deep sleep needs a short-lived arming bit. Software sets it with a control write, and the sleep instruction has to follow in the very next cycle. If it does not, the arming bit has already cleared itself and the device falls back to ordinary sleep.

In deep sleep the block waits for any of five wake sources and latches every source that fired. It then raises a one-cycle power-on reset request, which makes the core restart from its reset vector. The control bits and the arming bit return to their defaults. The wake-cause register and two general-purpose retention registers keep their contents, so software can read them after the restart. A wake from ordinary sleep or idle does not reset anything. Instead it passes through a fixed resume delay, counted in clock cycles, before execution continues.

Top module: `dsleep_ctrl`

## Requirements
- R1: After reset, `mode` is 0 (run), `cpu_run` is 1, and `reg_off`, `por_req`, `wake_cause`, `gpr0` and `gpr1` are all 0.
- R2: A control write (`ctl_we` in run mode) loads `ctl_wdata` as bit0 = arm, bit1 = regulator sleep, bit2 = idle select, bit3 = global interrupt enable. If `instr_sleep` arrives in the cycle right after a write with arm=1, regsleep=1, idle=0 and gie=0, `mode` becomes 3 (deep) on the following cycle.
- R3: The arm bit clears itself ARM_CYCLES cycles after the write. A sleep instruction that comes later enters ordinary sleep (`mode` 1) or idle (`mode` 2) instead of deep sleep.
- R4: A sleep instruction while armed, but with regsleep=0, idle=1 or gie=1, does not enter deep sleep. It enters idle (`mode` 2) when the idle bit is 1 and sleep (`mode` 1) otherwise.
- R5: `reg_off` is 1 exactly in the cycles in which `mode` is 3.
- R6: `wake_src` bits are bit0 reset pin, bit1 alarm, bit2 external interrupt, bit3 ultra-low-power wake, bit4 deep-sleep watchdog. Any set bit during deep sleep moves `mode` to 5 for exactly one cycle with `por_req`=1, and then back to run.
- R7: On deep wake, `wake_cause` records every `wake_src` bit that was set in the wake cycle, including several at once.
- R8: `wake_cause` clears on entry to deep sleep. Otherwise it holds its value, and `wake_src` pulses outside deep sleep have no effect on it.
- R9: `gpr_we[i]` writes `gpr_wdata` into retention register i, but only in run mode. Both registers keep their contents through deep sleep and the wake reset.
- R10: `wake_irq` in sleep or idle moves `mode` to 4 (resume) for exactly WAKE_DELAY cycles. After that `mode` returns to 0, and `cpu_run` is 1 only in run mode.
- R11: `instr_sleep`, `ctl_we` and `gpr_we` have no effect outside run mode.
- R12: The deep wake reset returns the control bits and the arm bit to 0. A sleep instruction issued right after a wake, with no new control write, enters ordinary sleep.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, one instruction cycle per edge |
| rst_n | input | 1 | Asynchronous cold reset, active low |
| instr_sleep | input | 1 | One-cycle sleep instruction strobe |
| ctl_we | input | 1 | Control register write strobe |
| ctl_wdata | input | 4 | Control bits: arm, regsleep, idle, gie |
| gpr_we | input | 2 | Retention register write strobes |
| gpr_wdata | input | DW | Retention register write data |
| wake_irq | input | 1 | Ordinary interrupt wake for sleep and idle |
| wake_src | input | 5 | Deep-sleep wake sources |
| mode | output | 3 | 0 run, 1 sleep, 2 idle, 3 deep, 4 resume, 5 wake reset |
| reg_off | output | 1 | Core regulator off request |
| por_req | output | 1 | Power-on reset request pulse |
| cpu_run | output | 1 | Core may execute |
| wake_cause | output | 5 | Latched deep wake sources |
| gpr0 | output | DW | Retention register 0 |
| gpr1 | output | DW | Retention register 1 |

## Verification
The bench builds the block with WAKE_DELAY = 5 and keeps ARM_CYCLES at 1 and DW at 8. The short delay means every resume window can be counted out in full, and each deep, sleep and idle round trip fits in a few dozen cycles. That leaves room to exercise the one-cycle arming window, each gating bit, and wake sources that fire together. With ARM_CYCLES at 1, the bench can place a sleep exactly one cycle too late and show that the block falls back to ordinary sleep.

// File: rtl/dsleep_pkg.sv
package dsleep_pkg;

  typedef enum logic [2:0] {
    M_RUN    = 3'd0,
    M_SLEEP  = 3'd1,
    M_IDLE   = 3'd2,
    M_DEEP   = 3'd3,
    M_RESUME = 3'd4,
    M_WRST   = 3'd5
  } pmode_e;

  localparam int NSRC   = 5;
  localparam int NCTL   = 4;
  localparam int B_ARM  = 0;
  localparam int B_RSLP = 1;
  localparam int B_IDLE = 2;
  localparam int B_GIE  = 3;

  // deep sleep is allowed only with arm live, regulator sleep set, idle and gie clear
  function automatic logic deep_gate(input logic armed, input logic rslp,
                                     input logic idle, input logic gie);
    return armed & rslp & ~idle & ~gie;
  endfunction

  // mode picked by a sleep instruction that is not allowed into deep sleep
  function automatic pmode_e light_mode(input logic idle);
    return idle ? M_IDLE : M_SLEEP;
  endfunction

  // last cycle of a resume window of len cycles
  function automatic logic window_end(input int unsigned cnt, input int unsigned len);
    return cnt == len - 1;
  endfunction

endpackage

// File: rtl/dsen_arm.sv
module dsen_arm #(
  parameter int ARM_CYCLES = 1,
  localparam int AW = $clog2(ARM_CYCLES + 1)
) (
  input  logic clk,
  input  logic rst_n,
  input  logic clr,
  input  logic load,
  input  logic load_val,
  output logic live
);

  logic [AW-1:0] life_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                 life_q <= '0;
    else if (clr)               life_q <= '0;
    else if (load)              life_q <= load_val ? AW'(ARM_CYCLES) : '0;
    else if (life_q != '0)      life_q <= life_q - 1'b1;
  end

  assign live = (life_q != '0);

  // R2
  arm_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (load && load_val && !clr) |=> live);

  // R12
  arm_clr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    clr |=> !live);

endmodule

// File: rtl/wake_cause_reg.sv
module wake_cause_reg #(
  parameter int NS = 5
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          clr,
  input  logic          cap,
  input  logic [NS-1:0] src,
  output logic [NS-1:0] cause
);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     cause <= '0;
    else if (clr)   cause <= '0;
    else if (cap)   cause <= src;
  end

  // R7
  cause_cap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cap && !clr) |=> (cause == $past(src)));

  // R8
  cause_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!cap && !clr) |=> $stable(cause));

endmodule

// File: rtl/resume_timer.sv
module resume_timer #(
  parameter int LEN = 16,
  localparam int CW = $clog2(LEN + 1)
) (
  input  logic clk,
  input  logic rst_n,
  input  logic start,
  output logic busy,
  output logic done
);
  import dsleep_pkg::*;

  logic [CW-1:0] cnt_q;

  assign done = busy && window_end(32'(cnt_q), LEN);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy  <= 1'b0;
      cnt_q <= '0;
    end else if (start) begin
      busy  <= 1'b1;
      cnt_q <= '0;
    end else if (done) begin
      busy  <= 1'b0;
      cnt_q <= '0;
    end else if (busy) begin
      cnt_q <= cnt_q + 1'b1;
    end
  end

  // R10
  tmr_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
    start |=> busy);

  // R10
  tmr_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !done && !start) |=> busy);

endmodule

// File: rtl/dsleep_ctrl.sv
module dsleep_ctrl #(
  parameter int DW         = 8,
  parameter int WAKE_DELAY = 16,
  parameter int ARM_CYCLES = 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          instr_sleep,
  input  logic          ctl_we,
  input  logic [3:0]    ctl_wdata,
  input  logic [1:0]    gpr_we,
  input  logic [DW-1:0] gpr_wdata,
  input  logic          wake_irq,
  input  logic [4:0]    wake_src,
  output logic [2:0]    mode,
  output logic          reg_off,
  output logic          por_req,
  output logic          cpu_run,
  output logic [4:0]    wake_cause,
  output logic [DW-1:0] gpr0,
  output logic [DW-1:0] gpr1
);
  import dsleep_pkg::*;

  localparam int NGPR = 2;

  pmode_e state_q, state_d;
  logic   rslp_q, idle_q, gie_q;
  logic   arm_live, deep_ok, in_run, any_wake;
  logic   deep_enter, por_enter, resume_start, tmr_busy, tmr_done;
  logic   ctl_load;
  logic [DW-1:0] gpr_q [NGPR];

  assign in_run       = (state_q == M_RUN);
  assign any_wake     = |wake_src;
  assign deep_ok      = deep_gate(arm_live, rslp_q, idle_q, gie_q);
  assign ctl_load     = in_run && ctl_we;
  assign deep_enter   = in_run && instr_sleep && deep_ok;
  assign por_enter    = (state_q == M_DEEP) && any_wake;
  assign resume_start = ((state_q == M_SLEEP) || (state_q == M_IDLE)) && wake_irq;

  dsen_arm #(.ARM_CYCLES(ARM_CYCLES)) u_arm (
    .clk(clk), .rst_n(rst_n), .clr(por_enter),
    .load(ctl_load), .load_val(ctl_wdata[B_ARM]), .live(arm_live)
  );

  wake_cause_reg #(.NS(NSRC)) u_cause (
    .clk(clk), .rst_n(rst_n), .clr(deep_enter),
    .cap(por_enter), .src(wake_src), .cause(wake_cause)
  );

  resume_timer #(.LEN(WAKE_DELAY)) u_tmr (
    .clk(clk), .rst_n(rst_n), .start(resume_start),
    .busy(tmr_busy), .done(tmr_done)
  );

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      M_RUN:    if (instr_sleep) state_d = deep_ok ? M_DEEP : light_mode(idle_q);
      M_SLEEP,
      M_IDLE:   if (wake_irq) state_d = M_RESUME;
      M_RESUME: if (tmr_done) state_d = M_RUN;
      M_DEEP:   if (any_wake) state_d = M_WRST;
      M_WRST:   state_d = M_RUN;
      default:  state_d = M_RUN;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) state_q <= M_RUN;
    else        state_q <= state_d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rslp_q <= 1'b0;
      idle_q <= 1'b0;
      gie_q  <= 1'b0;
    end else if (por_enter) begin
      rslp_q <= 1'b0;
      idle_q <= 1'b0;
      gie_q  <= 1'b0;
    end else if (ctl_load) begin
      rslp_q <= ctl_wdata[B_RSLP];
      idle_q <= ctl_wdata[B_IDLE];
      gie_q  <= ctl_wdata[B_GIE];
    end
  end

  for (genvar g = 0; g < NGPR; g++) begin : g_gpr
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                  gpr_q[g] <= '0;
      else if (in_run && gpr_we[g]) gpr_q[g] <= gpr_wdata;
    end
  end

  assign gpr0    = gpr_q[0];
  assign gpr1    = gpr_q[1];
  assign mode    = state_q;
  assign reg_off = (state_q == M_DEEP);
  assign por_req = (state_q == M_WRST);
  assign cpu_run = in_run;

  // R2
  deep_entry_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(reg_off) |-> ($past(instr_sleep) && $past(arm_live)));

  // R6
  por_after_wake_chk: assert property (@(posedge clk) disable iff (!rst_n)
    por_enter |=> (por_req && !reg_off));

  // R6
  por_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    por_req |=> (cpu_run && !por_req));

  // R8
  cause_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(reg_off) |-> (wake_cause == '0));

  // R9
  gpr_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !cpu_run |=> ($stable(gpr0) && $stable(gpr1)));

  // R10
  resume_exit_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (tmr_busy && tmr_done) |=> cpu_run);

endmodule

// File: tb/dsleep_ctrl_tb.sv
module dsleep_ctrl_tb;

  localparam int DW = 8;
  localparam int WD = 5;
  localparam int AC = 1;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          instr_sleep = 1'b0;
  logic          ctl_we = 1'b0;
  logic [3:0]    ctl_wdata = '0;
  logic [1:0]    gpr_we = '0;
  logic [DW-1:0] gpr_wdata = '0;
  logic          wake_irq = 1'b0;
  logic [4:0]    wake_src = '0;
  logic [2:0]    mode;
  logic          reg_off, por_req, cpu_run;
  logic [4:0]    wake_cause;
  logic [DW-1:0] gpr0, gpr1;

  int checks = 0;
  int errors = 0;
  int cyc = 0;

  always #10 clk = ~clk;

  dsleep_ctrl #(.DW(DW), .WAKE_DELAY(WD), .ARM_CYCLES(AC)) u_dut (
    .clk(clk), .rst_n(rst_n), .instr_sleep(instr_sleep), .ctl_we(ctl_we),
    .ctl_wdata(ctl_wdata), .gpr_we(gpr_we), .gpr_wdata(gpr_wdata),
    .wake_irq(wake_irq), .wake_src(wake_src), .mode(mode), .reg_off(reg_off),
    .por_req(por_req), .cpu_run(cpu_run), .wake_cause(wake_cause),
    .gpr0(gpr0), .gpr1(gpr1)
  );

  // behavioural reference: 0 run 1 sleep 2 idle 3 deep 4 resume 5 wake reset
  int m_md, m_arm, m_cnt, m_cause, m_g0, m_g1;
  bit m_rs, m_id, m_gie;

  always @(posedge clk) begin
    if (!rst_n) begin
      m_md = 0; m_arm = 0; m_cnt = 0; m_cause = 0; m_g0 = 0; m_g1 = 0;
      m_rs = 0; m_id = 0; m_gie = 0;
    end else begin
      int nmd, narm;
      nmd = m_md;
      narm = (m_arm > 0) ? m_arm - 1 : 0;
      if (m_md == 0) begin
        if (instr_sleep) begin
          if (m_arm > 0 && m_rs && !m_id && !m_gie) begin
            nmd = 3; m_cause = 0;
          end else nmd = m_id ? 2 : 1;
        end
        if (ctl_we) begin
          narm = ctl_wdata[0] ? AC : 0;
          m_rs = ctl_wdata[1]; m_id = ctl_wdata[2]; m_gie = ctl_wdata[3];
        end
        if (gpr_we[0]) m_g0 = gpr_wdata;
        if (gpr_we[1]) m_g1 = gpr_wdata;
      end else if (m_md == 1 || m_md == 2) begin
        if (wake_irq) begin nmd = 4; m_cnt = 0; end
      end else if (m_md == 4) begin
        if (m_cnt == WD - 1) nmd = 0; else m_cnt++;
      end else if (m_md == 3) begin
        if (wake_src != 0) begin
          nmd = 5; m_cause = wake_src; narm = 0;
          m_rs = 0; m_id = 0; m_gie = 0;
        end
      end else nmd = 0;
      m_md = nmd; m_arm = narm;
    end
  end

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s cycle %0d actual %0d expected %0d", tag, cyc, act, exp);
    end
  endtask

  always @(negedge clk) begin
    cyc++;
    if (rst_n) begin
      chk("R2 R3 R4 R6 R10 mode", mode, m_md);
      chk("R5 reg_off", reg_off, m_md == 3);
      chk("R6 por_req", por_req, m_md == 5);
      chk("R10 cpu_run", cpu_run, m_md == 0);
      chk("R7 R8 wake_cause", wake_cause, m_cause);
      chk("R9 gpr0", gpr0, m_g0);
      chk("R9 gpr1", gpr1, m_g1);
    end
    if (cyc > 20000) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  task automatic tick(input int n);
    for (int i = 0; i < n; i++) begin
      @(posedge clk); #2;
      instr_sleep = 0; ctl_we = 0; gpr_we = 0; wake_irq = 0; wake_src = 0;
    end
  endtask

  task automatic ctl(input logic [3:0] v);
    ctl_we = 1; ctl_wdata = v; tick(1);
  endtask

  task automatic slp();
    instr_sleep = 1; tick(1);
  endtask

  task automatic gw(input logic [1:0] we, input logic [DW-1:0] d);
    gpr_we = we; gpr_wdata = d; tick(1);
  endtask

  initial begin
    tick(3);
    rst_n = 1;
    @(negedge clk); #1;
    // R1 explicit reset values
    chk("R1 mode", mode, 0); chk("R1 cpu_run", cpu_run, 1);
    chk("R1 reg_off", reg_off, 0); chk("R1 por_req", por_req, 0);
    chk("R1 wake_cause", wake_cause, 0); chk("R1 gpr0", gpr0, 0);
    tick(1);
    // R9 write retention registers
    gw(2'b01, 8'hA5); gw(2'b10, 8'h3C);
    // R2 armed deep entry
    ctl(4'b0011); slp(); tick(1);
    @(negedge clk); #1; chk("R2 deep mode", mode, 3); chk("R5 reg_off", reg_off, 1);
    // R11 writes ignored in deep
    gw(2'b11, 8'hFF); ctl(4'b0101); tick(3);
    // R6 R7 two sources together
    wake_src = 5'b00110; tick(1);
    @(negedge clk); #1; chk("R6 por pulse", por_req, 1);
    tick(1);
    @(negedge clk); #1; chk("R7 cause", wake_cause, 6); chk("R9 gpr0 kept", gpr0, 8'hA5);
    // R12 sleep with no new write goes to ordinary sleep
    slp(); tick(2);
    wake_src = 5'b11111; tick(1);   // R8 ignored outside deep
    tick(1); wake_irq = 1; tick(WD + 3);
    // R3 sleep one cycle too late
    ctl(4'b0011); tick(1); slp(); tick(2);
    // R11 writes in sleep ignored
    ctl(4'b0011); gw(2'b01, 8'h11); wake_irq = 1; tick(WD + 2);
    slp(); tick(2); wake_irq = 1; tick(WD + 2);
    // R4 gating bits
    ctl(4'b0111); slp(); tick(2); wake_irq = 1; tick(WD + 2);
    ctl(4'b1011); slp(); tick(2); wake_irq = 1; tick(WD + 2);
    ctl(4'b0001); slp(); tick(2); wake_irq = 1; tick(WD + 2);
    // R10 wake_irq in deep ignored
    ctl(4'b0011); slp(); tick(1); wake_irq = 1; tick(2);
    @(negedge clk); #1; chk("R8 cause cleared", wake_cause, 0);
    // R7 watchdog and reset pin
    wake_src = 5'b10001; tick(3);
    gw(2'b10, 8'h77);
    // single source: alarm only
    ctl(4'b0011); slp(); tick(2); wake_src = 5'b00010; tick(3);
    @(negedge clk); #1; chk("R7 alarm cause", wake_cause, 2);
    tick(2);
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule